// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block computes the write-back image of a USB host transfer descriptor once the outcome of its bus transaction is known. It takes the descriptor's 32-bit control/status word, its 32-bit token word, and a result kind with an actual byte count. It returns the updated control word, a two-bit completion code for the queue walker, and four request lines. Two of the request lines ask for an end-of-frame interrupt: one for interrupt-on-complete and one for a detected short packet. The other two flag a bus error and a descriptor process error in the controller status.

A single request is accepted per clock when `in_valid` is high. The result appears on the registered outputs on the next clock edge, with `out_valid` high for exactly that cycle. The outputs hold their last value while no request is presented. Memory access, the bus transaction and queue traversal belong to neighbouring blocks.

The encodings used at the ports are as follows. Result kind: 0 success, 1 stall, 2 babble, 3 NAK, 4 timeout, 5 pending; 6 and 7 are also treated as pending. Completion code: 0 done, 1 skipped or unsuccessful, 2 pending, 3 fatal for the frame. Recognised PIDs in token bits 7:0: 0x2D SETUP, 0x69 IN, 0xE1 OUT. The maximum length is (token[31:21] + 1) mod 2048.

Top module: `td_status_updater`

## Requirements
- R1: While reset is asserted, and until the first request after it, `out_valid` and all outputs are zero. `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R2: If control bit 23 (active) is clear, the control word passes through unchanged with code 1 and no request line raised.
- R3: An active descriptor whose token bits 7:0 are not 0x2D, 0x69 or 0xE1 returns code 3 with the process error line high and the control word unchanged.
- R4: A pending result (kind 5, 6 or 7) on an active descriptor with a valid PID returns code 2 with the control word unchanged.
- R5: On success, control bits 10:0 become (actual length - 1) mod 2048, and bits 23 (active) and 19 (NAK) are cleared. The interrupt-on-complete line copies control bit 24, and the code is 0.
- R6: On success with PID IN and an actual length above the maximum length, bits 20 and 22 are also set and the bus error line is raised. The code is 3, and the length field and the interrupt-on-complete line are still updated as in R5.
- R7: On success without overrun, if control bit 29 (short-packet detect) is set and the actual length is below the maximum length, the short-packet line is raised and the code is 1. This applies for any PID.
- R8: A stall result sets bit 22, clears bit 23, raises the bus error line, copies bit 24 to the interrupt-on-complete line, and returns code 3.
- R9: A babble result sets bits 20 and 22, clears bit 23, raises the bus error line, copies bit 24 to the interrupt-on-complete line, and returns code 3.
- R10: A NAK result sets bit 19, leaves bit 23 as it was, and returns code 1. If the PID is SETUP, the timeout handling of R11 is applied on top of this.
- R11: A timeout sets bit 18. A nonzero error count in bits 28:27 is decremented and written back. When the count reaches zero, bit 23 is cleared, the bus error line is raised and bit 24 is copied to the interrupt-on-complete line. A count of zero stays zero and the descriptor stays active. The code is 1.
- R12: If control bit 25 (isochronous) is set, bit 23 is cleared before any non-pending result is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A descriptor and its result are presented |
| td_ctrl_i | input | 32 | Descriptor control/status word |
| td_token_i | input | 32 | Descriptor token word |
| res_kind_i | input | 3 | Transaction result kind |
| res_len_i | input | 12 | Actual byte count for a success result |
| out_valid | output | 1 | Registered outputs carry a fresh result |
| td_ctrl_o | output | 32 | Updated control/status word |
| code_o | output | 2 | Completion code |
| ioc_req_o | output | 1 | Interrupt-on-complete request |
| short_req_o | output | 1 | Short-packet interrupt request |
| usb_err_o | output | 1 | Bus error for the controller status |
| proc_err_o | output | 1 | Descriptor process error |

## Verification
Several relations are checked by assertions on every cycle:
- the valid timing;
- the unchanged pass-through of inactive descriptors;
- the unchanged pass-through of pending results;
- a process error always carrying the fatal code, and never coinciding with a bus error;
- a bus error always leaving the descriptor inactive;
- a short-packet request always carrying code 1.

Other behaviours can only be shown by the bench's sweep, which compares every output against arithmetic expectations over active, isochronous, interrupt, short-detect, NAK and error-count settings for every PID class and result kind. These are the exact length encoding and its wrap at 2048, the overrun and short-packet boundaries around the maximum length (including the zero-length maximum), the SETUP NAK turning into a timeout, and the retry counter's decrement and exhaustion.

// File: rtl/td_status_pkg.sv
package td_status_pkg;

  // Control word bit positions (fixed by the descriptor format)
  localparam int unsigned B_ACTIVE  = 23;
  localparam int unsigned B_STALL   = 22;
  localparam int unsigned B_BABBLE  = 20;
  localparam int unsigned B_NAK     = 19;
  localparam int unsigned B_TMO     = 18;
  localparam int unsigned B_IOC     = 24;
  localparam int unsigned B_ISO     = 25;
  localparam int unsigned B_SPD     = 29;
  localparam int unsigned ERR_LSB   = 27;

  // Packet identifiers
  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;

  // Result kinds
  localparam logic [2:0] RES_OK     = 3'd0;
  localparam logic [2:0] RES_STALL  = 3'd1;
  localparam logic [2:0] RES_BABBLE = 3'd2;
  localparam logic [2:0] RES_NAK    = 3'd3;
  localparam logic [2:0] RES_TMO    = 3'd4;

  typedef enum logic [1:0] {
    CODE_DONE  = 2'd0,
    CODE_SKIP  = 2'd1,
    CODE_PEND  = 2'd2,
    CODE_FATAL = 2'd3
  } td_code_e;

  typedef struct packed {
    logic [31:0] ctrl;
    td_code_e    code;
    logic        ioc;
    logic        spd;
    logic        usb_err;
    logic        proc_err;
  } td_upd_t;

endpackage

// File: rtl/td_rst_sync.sv
module td_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/td_len_eval.sv
module td_len_eval #(
  parameter int LEN_W = 11
) (
  input  logic [LEN_W-1:0] max_field_i,
  input  logic [LEN_W:0]   act_len_i,
  input  logic             is_in_i,
  output logic [LEN_W-1:0] enc_len_o,
  output logic             overrun_o,
  output logic             below_o
);
  logic [LEN_W-1:0] max_len;
  logic [LEN_W:0]   max_ext;
  logic [LEN_W:0]   len_m1;

  always_comb begin
    max_len   = max_field_i + 1'b1;   // wraps to zero at the top code
    max_ext   = {1'b0, max_len};
    len_m1    = act_len_i - 1'b1;
    enc_len_o = len_m1[LEN_W-1:0];
    overrun_o = is_in_i && (act_len_i > max_ext);
    below_o   = act_len_i < max_ext;
  end
endmodule

// File: rtl/td_retry.sv
module td_retry #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             exhausted_o
);
  always_comb begin
    if (cnt_i == '0) begin
      cnt_o       = '0;
      exhausted_o = 1'b0;
    end else begin
      cnt_o       = cnt_i - 1'b1;
      exhausted_o = (cnt_i == {{(CNT_W-1){1'b0}}, 1'b1});
    end
  end
endmodule

// File: rtl/td_status_core.sv
module td_status_core
  import td_status_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 2
) (
  input  logic [31:0]   ctrl_i,
  input  logic [31:0]   token_i,
  input  logic [2:0]    res_i,
  input  logic [LEN_W:0] len_i,
  output td_upd_t       upd_o
);
  localparam int MAXF_LSB = 32 - LEN_W;

  logic [7:0]       pid;
  logic             pid_ok;
  logic             is_in;
  logic [LEN_W-1:0] enc_len;
  logic             overrun;
  logic             below;
  logic [CNT_W-1:0] cnt_next;
  logic             exhausted;
  logic             unused_mid;

  assign pid        = token_i[7:0];
  assign is_in      = (pid == PID_IN);
  assign pid_ok     = (pid == PID_SETUP) || (pid == PID_IN) || (pid == PID_OUT);
  assign unused_mid = ^token_i[MAXF_LSB-1:8];

  td_len_eval #(.LEN_W(LEN_W)) u_len (
    .max_field_i (token_i[31:MAXF_LSB]),
    .act_len_i   (len_i),
    .is_in_i     (is_in),
    .enc_len_o   (enc_len),
    .overrun_o   (overrun),
    .below_o     (below)
  );

  td_retry #(.CNT_W(CNT_W)) u_retry (
    .cnt_i       (ctrl_i[ERR_LSB +: CNT_W]),
    .cnt_o       (cnt_next),
    .exhausted_o (exhausted)
  );

  logic [31:0] wctrl;
  logic        do_tmo;

  always_comb begin
    upd_o          = '0;
    upd_o.ctrl     = ctrl_i;
    upd_o.code     = CODE_SKIP;
    wctrl          = ctrl_i;
    do_tmo         = 1'b0;
    if (ctrl_i[B_ISO]) wctrl[B_ACTIVE] = 1'b0;

    if (!ctrl_i[B_ACTIVE]) begin
      upd_o.code = CODE_SKIP;
    end else if (!pid_ok) begin
      upd_o.code     = CODE_FATAL;
      upd_o.proc_err = 1'b1;
    end else begin
      case (res_i)
        RES_OK: begin
          wctrl[LEN_W-1:0] = enc_len;
          wctrl[B_ACTIVE]  = 1'b0;
          wctrl[B_NAK]     = 1'b0;
          upd_o.ioc        = ctrl_i[B_IOC];
          if (overrun) begin
            wctrl[B_BABBLE] = 1'b1;
            wctrl[B_STALL]  = 1'b1;
            upd_o.usb_err   = 1'b1;
            upd_o.code      = CODE_FATAL;
          end else if (ctrl_i[B_SPD] && below) begin
            upd_o.spd  = 1'b1;
            upd_o.code = CODE_SKIP;
          end else begin
            upd_o.code = CODE_DONE;
          end
          upd_o.ctrl = wctrl;
        end
        RES_STALL, RES_BABBLE: begin
          wctrl[B_STALL]  = 1'b1;
          if (res_i == RES_BABBLE) wctrl[B_BABBLE] = 1'b1;
          wctrl[B_ACTIVE] = 1'b0;
          upd_o.usb_err   = 1'b1;
          upd_o.ioc       = ctrl_i[B_IOC];
          upd_o.code      = CODE_FATAL;
          upd_o.ctrl      = wctrl;
        end
        RES_NAK: begin
          wctrl[B_NAK] = 1'b1;
          do_tmo       = (pid == PID_SETUP);
          upd_o.code   = CODE_SKIP;
          upd_o.ctrl   = wctrl;
        end
        RES_TMO: begin
          do_tmo     = 1'b1;
          upd_o.code = CODE_SKIP;
        end
        default: begin
          upd_o.code = CODE_PEND;
        end
      endcase

      if (do_tmo) begin
        wctrl[B_TMO]                = 1'b1;
        wctrl[ERR_LSB +: CNT_W]     = cnt_next;
        if (exhausted) begin
          wctrl[B_ACTIVE] = 1'b0;
          upd_o.usb_err   = 1'b1;
          upd_o.ioc       = ctrl_i[B_IOC];
        end
        upd_o.ctrl = wctrl;
      end
    end
  end
endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
  import td_status_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       td_ctrl_i,
  input  logic [31:0]       td_token_i,
  input  logic [2:0]        res_kind_i,
  input  logic [LEN_W:0]    res_len_i,
  output logic              out_valid,
  output logic [31:0]       td_ctrl_o,
  output logic [1:0]        code_o,
  output logic              ioc_req_o,
  output logic              short_req_o,
  output logic              usb_err_o,
  output logic              proc_err_o
);
  logic    rst_core_n;
  td_upd_t upd_d;
  td_upd_t upd_q;
  logic    vld_q;

  td_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  td_status_core #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_core (
    .ctrl_i  (td_ctrl_i),
    .token_i (td_token_i),
    .res_i   (res_kind_i),
    .len_i   (res_len_i),
    .upd_o   (upd_d)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q <= 1'b0;
      upd_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) upd_q <= upd_d;
    end
  end

  assign out_valid   = vld_q;
  assign td_ctrl_o   = upd_q.ctrl;
  assign code_o      = upd_q.code;
  assign ioc_req_o   = upd_q.ioc;
  assign short_req_o = upd_q.spd;
  assign usb_err_o   = upd_q.usb_err;
  assign proc_err_o  = upd_q.proc_err;
endmodule

// File: rtl/td_status_checker.sv
module td_status_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] td_ctrl_i,
  input logic [31:0] td_token_i,
  input logic [2:0]  res_kind_i,
  input logic        out_valid,
  input logic [31:0] td_ctrl_o,
  input logic [1:0]  code_o,
  input logic        short_req_o,
  input logic        usb_err_o,
  input logic        proc_err_o
);
  logic pid_ok;
  assign pid_ok = (td_token_i[7:0] == 8'h2D) || (td_token_i[7:0] == 8'h69) ||
                  (td_token_i[7:0] == 8'hE1);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R1
  AST_INACTIVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !td_ctrl_i[23]) |=> (td_ctrl_o == $past(td_ctrl_i) && code_o == 2'd1));  // R2
  AST_PROC_ERR_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && proc_err_o) |-> (code_o == 2'd3 && !usb_err_o));  // R3
  AST_PEND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && td_ctrl_i[23] && pid_ok && res_kind_i >= 3'd5)
      |=> (td_ctrl_o == $past(td_ctrl_i) && code_o == 2'd2));  // R4
  AST_SHORT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && short_req_o) |-> code_o == 2'd1);  // R7
  AST_ERR_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && usb_err_o) |-> !td_ctrl_o[23]);  // R8
endmodule

bind td_status_updater td_status_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .in_valid    (in_valid),
  .td_ctrl_i   (td_ctrl_i),
  .td_token_i  (td_token_i),
  .res_kind_i  (res_kind_i),
  .out_valid   (out_valid),
  .td_ctrl_o   (td_ctrl_o),
  .code_o      (code_o),
  .short_req_o (short_req_o),
  .usb_err_o   (usb_err_o),
  .proc_err_o  (proc_err_o)
);

// File: tb/td_status_updater_test.sv
module td_status_updater_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] td_ctrl_i;
  logic [31:0] td_token_i;
  logic [2:0]  res_kind_i;
  logic [11:0] res_len_i;
  logic        out_valid;
  logic [31:0] td_ctrl_o;
  logic [1:0]  code_o;
  logic        ioc_req_o, short_req_o, usb_err_o, proc_err_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  td_status_updater uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .td_ctrl_i(td_ctrl_i), .td_token_i(td_token_i),
    .res_kind_i(res_kind_i), .res_len_i(res_len_i),
    .out_valid(out_valid), .td_ctrl_o(td_ctrl_o), .code_o(code_o),
    .ioc_req_o(ioc_req_o), .short_req_o(short_req_o),
    .usb_err_o(usb_err_o), .proc_err_o(proc_err_o)
  );

  initial clk = 0;
  always #2 clk = ~clk;   // 250 MHz

  // Expected {ctrl, code, ioc, spd, uerr, perr}
  function automatic logic [37:0] model(input logic [31:0] c, input logic [31:0] t,
                                        input logic [2:0] r, input logic [11:0] l);
    logic [31:0] w;
    logic [1:0]  code;
    logic        ioc, spd, ue, tmo;
    logic [1:0]  e;
    int maxl, enc;
    logic [7:0]  pid;
    pid  = t[7:0];
    maxl = ((int'(t[31:21])) + 1) % 2048;
    enc  = (int'(l) + 2047) % 2048;
    w = c; ioc = 0; spd = 0; ue = 0; tmo = 0; code = 2'd1;
    if (!c[23]) return {c, 2'd1, 4'b0000};
    if (pid != 8'h2D && pid != 8'h69 && pid != 8'hE1) return {c, 2'd3, 4'b0001};
    if (r >= 3'd5) return {c, 2'd2, 4'b0000};
    if (c[25]) w[23] = 0;
    case (r)
      3'd0: begin
        w[10:0] = enc[10:0]; w[23] = 0; w[19] = 0; ioc = c[24];
        if (pid == 8'h69 && int'(l) > maxl) begin w[20] = 1; w[22] = 1; ue = 1; code = 2'd3; end
        else if (c[29] && int'(l) < maxl) begin spd = 1; code = 2'd1; end
        else code = 2'd0;
      end
      3'd1: begin w[22] = 1; w[23] = 0; ue = 1; ioc = c[24]; code = 2'd3; end
      3'd2: begin w[22] = 1; w[20] = 1; w[23] = 0; ue = 1; ioc = c[24]; code = 2'd3; end
      3'd3: begin w[19] = 1; code = 2'd1; tmo = (pid == 8'h2D); end
      default: begin tmo = 1; code = 2'd1; end
    endcase
    if (tmo) begin
      w[18] = 1;
      e = c[28:27];
      if (e != 0) begin
        e = e - 1;
        if (e == 0) begin w[23] = 0; ue = 1; ioc = c[24]; end
      end
      w[28:27] = e;
    end
    return {w, code, ioc, spd, ue, 1'b0};
  endfunction

  function automatic string tag_of(input logic [31:0] c, input logic [31:0] t,
                                   input logic [2:0] r, input logic [11:0] l);
    int maxl;
    maxl = ((int'(t[31:21])) + 1) % 2048;
    if (!c[23]) return "R2";
    if (t[7:0] != 8'h2D && t[7:0] != 8'h69 && t[7:0] != 8'hE1) return "R3";
    if (r >= 3'd5) return "R4";
    if (r == 3'd0) begin
      if (t[7:0] == 8'h69 && int'(l) > maxl) return "R6";
      if (c[29] && int'(l) < maxl) return "R7";
    end
    if (c[25]) return "R12";
    case (r)
      3'd0: return "R5";
      3'd1: return "R8";
      3'd2: return "R9";
      3'd3: return (t[7:0] == 8'h2D) ? "R11" : "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] c, input logic [31:0] t,
                       input logic [2:0] r, input logic [11:0] l);
    @(negedge clk);
    in_valid = 1; td_ctrl_i = c; td_token_i = t; res_kind_i = r; res_len_i = l;
    @(negedge clk);
    in_valid = 0;
    check(tag_of(c, t, r, l),
          {td_ctrl_o, code_o, ioc_req_o, short_req_o, usb_err_o, proc_err_o},
          model(c, t, r, l));
    if (out_valid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R1 actual=%b expected=1", out_valid);
    end
  endtask

  initial begin
    logic [7:0]  pids [4];
    logic [10:0] maxf [3];
    logic [11:0] lens [5];
    pids = '{8'h2D, 8'h69, 8'hE1, 8'hA5};
    maxf = '{11'd0, 11'd7, 11'h7FF};
    lens = '{12'd0, 12'd1, 12'd8, 12'd9, 12'd2048};
    rst_n = 0; in_valid = 0; td_ctrl_i = '0; td_token_i = '0; res_kind_i = '0; res_len_i = '0;
    repeat (5) @(negedge clk);
    // R1: reset state
    checks++;
    if ({out_valid, td_ctrl_o, code_o, ioc_req_o, short_req_o, usb_err_o, proc_err_o} !== '0) begin
      errors++;
      $display("FAIL R1 actual=%h expected=0", {out_valid, td_ctrl_o, code_o});
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || td_ctrl_o !== '0) begin
      errors++;
      $display("FAIL R1 actual=%b expected=0", out_valid);
    end

    for (int a = 0; a < 2; a++)
    for (int iso = 0; iso < 2; iso++)
    for (int ioc = 0; ioc < 2; ioc++)
    for (int sp = 0; sp < 2; sp++)
    for (int e = 0; e < 4; e++)
    for (int nk = 0; nk < 2; nk++)
    for (int p = 0; p < 4; p++)
    for (int r = 0; r < 6; r++)
    for (int m = 0; m < 3; m++)
    for (int li = 0; li < 5; li++) begin
      logic [31:0] c;
      logic [31:0] t;
      c = 32'hC424_05A5;
      c[23] = a[0]; c[25] = iso[0]; c[24] = ioc[0]; c[29] = sp[0];
      c[28:27] = e[1:0]; c[19] = nk[0];
      t = {maxf[m], 13'h0A55, pids[p]};
      apply(c, t, r[2:0], lens[li]);
    end

    // R4: reserved result kinds behave as pending
    apply(32'h0080_0000, {11'd7, 13'd0, 8'hE1}, 3'd6, 12'd3);
    apply(32'h0080_0000, {11'd7, 13'd0, 8'h69}, 3'd7, 12'd3);

    // R1: out_valid drops when no request is presented
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 actual=%b expected=0", out_valid);
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule